// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block is the digital divider chain of a frequency synthesizer. One path divides the reference clock down to the phase-comparison rate. The other path divides the oscillator clock by a programmable total. It does this with a dual-modulus prescaler that divides by 32 or 33, a main counter and a swallow counter. Each path produces a one-cycle pulse at its output rate, and a phase detector outside the block compares the two pulses.

The feedback total is 32 times the main count plus the effective swallow count. The main count is 86 plus a 2-bit code. The swallow count is the 5-bit code. In receive mode the total is one higher, which places the receive channel one step above the transmit channel for the same code. New feedback settings are captured by a strobe and take effect only at the next feedback-cycle boundary. The reference-select input takes effect only at the next reference-cycle boundary. As a result, no output period is ever a mix of two settings.

Top module: `synth_fb_divider`

## Requirements
- R1: The 2-bit main code values 0, 1, 2 and 3 give a main count of 86, 87, 88 and 89. Each feedback period contains exactly that many prescaler output pulses, and the last of them coincides with the feedback pulse.
- R2: In transmit mode (`rx_mode`=0) the spacing between feedback pulses is exactly 32*main + swallow oscillator cycles, where the swallow count is the 5-bit code taken as is (0..31). For example, main code 0 with swallow 27 gives 2779.
- R3: In receive mode (`rx_mode`=1) the spacing is 32*main + swallow + 1. This also holds for swallow 31, which gives 32*main + 32.
- R4: Within each feedback period, the first (swallow + rx_mode) prescaler cycles last 33 oscillator cycles and the rest last 32. The swallow cycles still owed never reach the main cycles still owed.
- R5: `fb_pulse` is high for exactly one oscillator cycle per feedback period.
- R6: With `ref_sel`=0 the reference pulse repeats every 6 reference cycles, and with `ref_sel`=1 every 8 cycles. Each pulse is one reference cycle wide.
- R7: A `cfg_load` strobe captures the code and mode inputs. They govern the feedback period that starts after the next boundary, so the period in progress keeps its old setting. Input changes without a strobe have no effect.
- R8: A change of `ref_sel` in the middle of a reference period leaves that period's length unchanged and applies from the following period.
- R9: During reset (synchronous, active low) all three outputs are low. After release, the first feedback pulse appears after the full division of the settings present at reset, and the first reference pulse after the full reference division.
- R10: The largest setting (main code 3, swallow 31, receive) gives a spacing of 2880 oscillator cycles. The smallest (main code 0, swallow 0, transmit) gives 2752.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, divided by the feedback path |
| ref_clk | input | 1 | Reference clock, divided by the reference path |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| ref_sel | input | 1 | Reference rate select: 0 divides by 6, 1 divides by 8 |
| mc_code | input | 2 | Main counter code, main count = 86 + code |
| sc_code | input | 5 | Swallow count, 0..31 |
| rx_mode | input | 1 | 0 transmit, 1 receive (adds one to the division) |
| cfg_load | input | 1 | One-cycle strobe in the oscillator domain that captures the codes and mode |
| ref_pulse | output | 1 | One-cycle pulse at the comparison rate, reference domain |
| presc_out | output | 1 | One-cycle pulse at the end of each prescaler cycle |
| fb_pulse | output | 1 | One-cycle pulse at the end of each feedback period |

## Verification
The hardest case to reach from the ports is the moment of change. The old setting must hold for the whole period in which the strobe lands, and the new one must start at the very next boundary. The inputs must also be shown to be ignored while they hold unrelated values. The stimulus issues a strobe on the cycle a feedback pulse is seen and scrambles the code inputs in the middle of every period. A run of back-to-back settings then checks each period against the setting strobed one period earlier. Prescaler intervals are timed inside every period, so the split between 33-cycle and 32-cycle prescaler cycles is checked for every swallow value, including the receive case where 32 cycles are swallowed.

// File: rtl/sd_div_pkg.sv
package sd_div_pkg;

  typedef enum logic {
    MODE_TX = 1'b0,
    MODE_RX = 1'b1
  } link_mode_e;

  // main count selected by the main-counter code
  function automatic int unsigned main_count(input int unsigned base,
                                             input int unsigned code);
    return base + code;
  endfunction

  // swallowed prescaler cycles per feedback period
  function automatic int unsigned swallow_eff(input int unsigned sc,
                                              input link_mode_e mode);
    return sc + ((mode == MODE_RX) ? 1 : 0);
  endfunction

  // overall oscillator cycles per feedback pulse
  function automatic int unsigned total_div(input int unsigned pre_lo,
                                            input int unsigned base,
                                            input int unsigned code,
                                            input int unsigned sc,
                                            input link_mode_e mode);
    return pre_lo * main_count(base, code) + swallow_eff(sc, mode);
  endfunction

endpackage

// File: rtl/sd_ref_div.sv
module sd_ref_div #(
  parameter int LO_DIV = 6,
  parameter int HI_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic pulse
);
  localparam int CW = $clog2(HI_DIV);
  localparam logic [CW-1:0] LO_LAST = CW'(LO_DIV - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HI_DIV - 1);

  logic [CW-1:0] cnt;
  logic          sel_q;
  logic          wrap;

  assign wrap = (cnt == (sel_q ? HI_LAST : LO_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_q <= sel;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap;
      if (wrap) begin
        cnt   <= '0;
        sel_q <= sel;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_dual_prescaler.sv
module sd_dual_prescaler #(
  parameter int PRE_LO = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic high_mod,
  output logic wrap
);
  localparam int PW = $clog2(PRE_LO + 1);
  localparam logic [PW-1:0] LAST_LO = PW'(PRE_LO - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(PRE_LO);

  logic [PW-1:0] cnt;

  assign wrap = (cnt == (high_mod ? LAST_HI : LAST_LO));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (wrap) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sd_swallow_ctrl.sv
module sd_swallow_ctrl
  import sd_div_pkg::*;
#(
  parameter int MAIN_BASE = 86,
  parameter int MC_W      = 2,
  parameter int SC_W      = 5,
  localparam int MW = $clog2(MAIN_BASE + (1 << MC_W)),
  localparam int SW = SC_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_wrap,
  input  logic            load,
  input  logic [MC_W-1:0] mc_in,
  input  logic [SC_W-1:0] sc_in,
  input  link_mode_e      mode_in,
  output logic            high_mod,
  output logic            cyc_end,
  output logic [MW-1:0]   mc_left,
  output logic [SW-1:0]   sw_left,
  output logic [MC_W-1:0] act_mc,
  output logic [SC_W-1:0] act_sc,
  output link_mode_e      act_mode
);
  logic [MC_W-1:0] pend_mc, nxt_mc;
  logic [SC_W-1:0] pend_sc, nxt_sc;
  link_mode_e      pend_mode, nxt_mode;
  logic            pend_vld;
  logic [MW-1:0]   reload_m, rst_m;
  logic [SW-1:0]   reload_s, rst_s;

  assign high_mod = (sw_left != '0);
  assign cyc_end  = pre_wrap && (mc_left == MW'(1));

  always_comb begin
    nxt_mc   = pend_vld ? pend_mc   : act_mc;
    nxt_sc   = pend_vld ? pend_sc   : act_sc;
    nxt_mode = pend_vld ? pend_mode : act_mode;
    reload_m = MW'(main_count(MAIN_BASE, int'(nxt_mc)));
    reload_s = SW'(swallow_eff(int'(nxt_sc), nxt_mode));
    rst_m    = MW'(main_count(MAIN_BASE, int'(mc_in)));
    rst_s    = SW'(swallow_eff(int'(sc_in), mode_in));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mc   <= mc_in;
      pend_sc   <= sc_in;
      pend_mode <= mode_in;
      pend_vld  <= 1'b0;
      act_mc    <= mc_in;
      act_sc    <= sc_in;
      act_mode  <= mode_in;
      mc_left   <= rst_m;
      sw_left   <= rst_s;
    end else begin
      if (load) begin
        pend_mc   <= mc_in;
        pend_sc   <= sc_in;
        pend_mode <= mode_in;
      end
      pend_vld <= load | (pend_vld & ~cyc_end);
      if (cyc_end) begin
        act_mc   <= nxt_mc;
        act_sc   <= nxt_sc;
        act_mode <= nxt_mode;
        mc_left  <= reload_m;
        sw_left  <= reload_s;
      end else if (pre_wrap) begin
        mc_left <= mc_left - 1'b1;
        if (sw_left != '0) sw_left <= sw_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_fb_divider.sv
module synth_fb_divider
  import sd_div_pkg::*;
#(
  parameter int PRE_LO     = 32,
  parameter int MAIN_BASE  = 86,
  parameter int MC_W       = 2,
  parameter int SC_W       = 5,
  parameter int REF_LO_DIV = 6,
  parameter int REF_HI_DIV = 8
) (
  input  logic            osc_clk,
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic            ref_sel,
  input  logic [MC_W-1:0] mc_code,
  input  logic [SC_W-1:0] sc_code,
  input  logic            rx_mode,
  input  logic            cfg_load,
  output logic            ref_pulse,
  output logic            presc_out,
  output logic            fb_pulse
);
  localparam int MW = $clog2(MAIN_BASE + (1 << MC_W));
  localparam int SW = SC_W + 1;

  // named internal events, observed by the bound checker
  logic            pre_wrap;
  logic            pre_high;
  logic            cyc_end;
  logic [MW-1:0]   mc_left;
  logic [SW-1:0]   sw_left;
  logic [MC_W-1:0] act_mc;
  logic [SC_W-1:0] act_sc;
  link_mode_e      act_mode;
  link_mode_e      mode_in;

  assign mode_in = rx_mode ? MODE_RX : MODE_TX;

  sd_ref_div #(.LO_DIV(REF_LO_DIV), .HI_DIV(REF_HI_DIV)) u_ref (
    .clk  (ref_clk),
    .rst_n(rst_n),
    .sel  (ref_sel),
    .pulse(ref_pulse)
  );

  sd_dual_prescaler #(.PRE_LO(PRE_LO)) u_pre (
    .clk     (osc_clk),
    .rst_n   (rst_n),
    .high_mod(pre_high),
    .wrap    (pre_wrap)
  );

  sd_swallow_ctrl #(.MAIN_BASE(MAIN_BASE), .MC_W(MC_W), .SC_W(SC_W)) u_ctl (
    .clk     (osc_clk),
    .rst_n   (rst_n),
    .pre_wrap(pre_wrap),
    .load    (cfg_load),
    .mc_in   (mc_code),
    .sc_in   (sc_code),
    .mode_in (mode_in),
    .high_mod(pre_high),
    .cyc_end (cyc_end),
    .mc_left (mc_left),
    .sw_left (sw_left),
    .act_mc  (act_mc),
    .act_sc  (act_sc),
    .act_mode(act_mode)
  );

  always_ff @(posedge osc_clk) begin
    if (!rst_n) begin
      presc_out <= 1'b0;
      fb_pulse  <= 1'b0;
    end else begin
      presc_out <= pre_wrap;
      fb_pulse  <= cyc_end;
    end
  end
endmodule

// File: rtl/sd_div_chk.sv
module sd_div_chk #(
  parameter int MAIN_BASE = 86,
  parameter int MC_W      = 2,
  parameter int SC_W      = 5,
  localparam int MW = $clog2(MAIN_BASE + (1 << MC_W)),
  localparam int SW = SC_W + 1
) (
  input logic            osc_clk,
  input logic            ref_clk,
  input logic            rst_n,
  input logic            pre_wrap,
  input logic            pre_high,
  input logic            cyc_end,
  input logic            presc_out,
  input logic            fb_pulse,
  input logic            ref_pulse,
  input logic [MW-1:0]   mc_left,
  input logic [SW-1:0]   sw_left,
  input logic [MC_W-1:0] act_mc,
  input logic [SC_W-1:0] act_sc,
  input logic            act_rx
);
  // R4
  swallow_below_main_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    {1'b0, sw_left} < {{(SW+1-MW > 0 ? 0 : 0){1'b0}}, (MW > SW) ? MW'(mc_left) : MW'(mc_left)});

  // R4
  mod_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !$past(pre_wrap) |-> $stable(pre_high));

  // R3
  rx_reload_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cyc_end |=> (sw_left == (SW'(act_sc) + SW'(act_rx))));

  // R5
  fb_single_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R1
  fb_on_presc_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    fb_pulse |-> presc_out);

  // R7
  cfg_at_bound_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !$stable({act_mc, act_sc, act_rx}) |-> $past(cyc_end));

  // R6
  ref_single_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);
endmodule

bind synth_fb_divider sd_div_chk #(
  .MAIN_BASE(MAIN_BASE), .MC_W(MC_W), .SC_W(SC_W)
) u_chk (
  .osc_clk  (osc_clk),
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .pre_wrap (pre_wrap),
  .pre_high (pre_high),
  .cyc_end  (cyc_end),
  .presc_out(presc_out),
  .fb_pulse (fb_pulse),
  .ref_pulse(ref_pulse),
  .mc_left  (mc_left),
  .sw_left  (sw_left),
  .act_mc   (act_mc),
  .act_sc   (act_sc),
  .act_rx   (act_mode)
);

// File: tb/tb_synth_fb_divider.sv
`timescale 1ns/1ps
module tb_synth_fb_divider;
  logic       osc_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       ref_sel = 1'b0;
  logic [1:0] mc_code = 2'd0;
  logic [4:0] sc_code = 5'd27;
  logic       rx_mode = 1'b0;
  logic       cfg_load = 1'b0;
  logic       ref_pulse, presc_out, fb_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  synth_fb_divider dut (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .rst_n(rst_n), .ref_sel(ref_sel),
    .mc_code(mc_code), .sc_code(sc_code), .rx_mode(rx_mode), .cfg_load(cfg_load),
    .ref_pulse(ref_pulse), .presc_out(presc_out), .fb_pulse(fb_pulse)
  );

  always #5 osc_clk = ~osc_clk;
  always #6.5 ref_clk = ~ref_clk;

  function automatic int exp_div(input int m, input int s, input int r);
    return 32 * (86 + m) + s + r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one feedback period; entered at the negedge where the previous pulse was seen
  task automatic fb_period(input int m, input int s, input int r, input string req);
    int cnt = 0;
    int pc = 0;
    int pi = 0;
    int badv = 0;
    int bexp = 0;
    int wide = 0;
    bit bad = 1'b0;
    bit seen = 1'b0;
    int n = exp_div(m, s, r);
    while (!seen && cnt < 4000) begin
      @(negedge osc_clk);
      cnt++;
      pc++;
      if (cnt == 1) begin
        cfg_load = 1'b0;
        wide = fb_pulse;
      end
      if (cnt == 40) begin
        // R7: no strobe, these values must be ignored
        mc_code = ~mc_code;
        sc_code = ~sc_code;
        rx_mode = ~rx_mode;
      end
      if (presc_out) begin
        int e = (pi < s + r) ? 33 : 32;
        if (pc != e && !bad) begin
          bad = 1'b1; badv = pc; bexp = e;
        end
        pc = 0;
        pi++;
      end
      if (fb_pulse) seen = 1'b1;
    end
    check(wide == 0, "R5 pulse width one cycle", wide, 0);
    check(cnt == n, req, cnt, n);
    check(!bad, "R4 prescaler interval", badv, bexp);
    check(pi == 86 + m, "R1 prescaler pulses per period", pi, 86 + m);
  endtask

  task automatic ref_wait(input int exp, input string req, input int chg_at, input bit nsel);
    int c = 0;
    bit seen = 1'b0;
    int wide = 0;
    while (!seen && c < 40) begin
      @(posedge ref_clk);
      #1;
      c++;
      if (c == 1) wide = ref_pulse;
      if (c == chg_at) ref_sel = nsel;
      if (ref_pulse) seen = 1'b1;
    end
    if (exp > 1) check(wide == 0, "R6 reference pulse width", wide, 0);
    check(c == exp, req, c, exp);
  endtask

  task automatic ref_seq();
    ref_wait(6, "R9 first reference pulse", 0, 1'b0);
    ref_wait(6, "R6 divide by 6", 0, 1'b0);
    ref_wait(6, "R8 period in progress keeps old select", 2, 1'b1);
    ref_wait(8, "R8 new select applied", 0, 1'b1);
    ref_wait(8, "R6 divide by 8", 0, 1'b1);
    ref_wait(8, "R8 period in progress keeps select 1", 3, 1'b0);
    ref_wait(6, "R8 back to divide by 6", 0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int pm = 0, ps = 27, pr = 0;
    repeat (6) @(negedge osc_clk);
    check(fb_pulse == 0, "R9 fb low in reset", fb_pulse, 0);
    check(presc_out == 0, "R9 presc low in reset", presc_out, 0);
    check(ref_pulse == 0, "R9 ref low in reset", ref_pulse, 0);
    @(negedge osc_clk);
    rst_n = 1'b1;
    fork
      fb_period(0, 27, 0, "R9 R2 first feedback pulse after reset");
      ref_seq();
    join
    for (int i = 0; i < 36; i++) begin
      int m, s, r;
      string t;
      if (i < 32) begin
        m = i % 4; s = i; r = (i % 3 == 0) ? 1 : 0;
      end else if (i == 32) begin
        m = 3; s = 31; r = 1;
      end else if (i == 33) begin
        m = 0; s = 0; r = 0;
      end else if (i == 34) begin
        m = 2; s = 31; r = 0;
      end else begin
        m = 1; s = 0; r = 1;
      end
      mc_code = 2'(m);
      sc_code = 5'(s);
      rx_mode = r[0];
      cfg_load = 1'b1;
      if (pm == 3 && ps == 31 && pr == 1) t = "R10 largest division (R7 old setting held)";
      else if (pm == 0 && ps == 0 && pr == 0) t = "R10 smallest division (R7 old setting held)";
      else if (pr == 1) t = "R3 receive offset (R7 old setting held)";
      else t = "R2 transmit division (R7 old setting held)";
      fb_period(pm, ps, pr, t);
      pm = m; ps = s; pr = r;
    end
    fb_period(pm, ps, pr, "R7 unstrobed inputs ignored, R3 receive offset");
    fb_period(pm, ps, pr, "R7 setting persists without strobe");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule